// File: doc/BRIEF.md
# Deferred Store Holding Buffer

This block sits between a pipelined core and a data cache whose tag comparison completes one cycle after the array access. A store does not write the array when it is issued. Its word address, data and byte enables are captured into a single holding entry. The tag result for that store arrives in the following cycle. A hit confirms the entry and a miss throws it away. The array can never be written before the tag comparison is known, because a write to the array cannot be taken back.

A confirmed entry is written to the array in the first cycle in which the array is not busy with a load. That cycle may be the one in which the hit is reported. A later store also frees the array, so when a store arrives the old entry is written during that store's access cycle. A flush request forces the write even when a load is present. While the entry is held, every load compares its word address with the held address. On a match, the enabled bytes come from the entry and the other bytes come from the cache read data. The core issues at most one load or one store per cycle.

Top module: `store_hold_buffer`

## Requirements
- R1: After reset the buffer reports empty (`empty_o`=1), and `cw_en` and `miss_o` are 0.
- R2: A held store is never written to the array before its tag result is known. In the cycle after a store, with `tc_ok`=0 and no new store, `cw_en` is 0 and no data is forwarded.
- R3: In a cycle with no load, a confirmed entry, or one confirmed by `tc_ok`=1 in that cycle, is written. `cw_en`=1, and `cw_addr`, `cw_data` and `cw_be` equal the captured store. The buffer is empty in the next cycle.
- R4: A load in a cycle without flush or store holds the write back (`cw_en`=0). The entry stays held, so `empty_o` is 0 in the next cycle.
- R5: A store that arrives while a confirmed entry is held writes the old entry in that same cycle. It then occupies the buffer itself.
- R6: In the cycle after a store, `tc_ok`=0 raises `miss_o` for that cycle and writes nothing. The entry is discarded, so the buffer is empty in the next cycle.
- R7: A load whose `ld_addr` equals the held word address, while the entry is confirmed or being confirmed, returns held byte i on `ld_data[8i+7:8i]` where `st_be[i]`=1. It returns `cache_rdata` for the other bytes.
- R8: A load to a different word address, or a load while the buffer is empty, returns `cache_rdata` unchanged.
- R9: `flush`=1 with a confirmed entry writes that entry in the same cycle, even when a load is present.
- R10: `empty_o` is 1 exactly when no store is held, and `cw_en` is never 1 while `empty_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store issued this cycle |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| tc_ok | input | 1 | Tag result for the store issued last cycle (1 = hit) |
| ld_valid | input | 1 | Load uses the array this cycle |
| ld_addr | input | AW | Load word address |
| cache_rdata | input | DW | Data read from the array |
| flush | input | 1 | Force write of a confirmed entry |
| ld_data | output | DW | Load result after byte merge |
| cw_en | output | 1 | Array write strobe |
| cw_addr | output | AW | Array write word address |
| cw_data | output | DW | Array write data |
| cw_be | output | DW/8 | Array write byte enables |
| miss_o | output | 1 | Held store discarded on tag miss |
| empty_o | output | 1 | No store held |

## Verification
The bench sweeps all 16 byte-enable values. For each value it runs four store sequences.

- **Load during confirmation, then an idle write.** A load in the confirming cycle separates byte-accurate forwarding from a stall of the write, and the following idle cycle shows the write fields.
- **Tag miss.** This shows that a rejected store is dropped and never written.
- **Back-to-back stores.** The second store must carry out the first one's write in its own cycle, and then keep its own entry.
- **Flush under a load.** This separates the forced write from an ordinary stall.

Loads to other addresses and loads to an empty buffer check that unrelated reads pass through unchanged.

// File: rtl/store_hold_buffer.sv
module store_hold_buffer #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [DW/8-1:0] st_be,
  input  logic            tc_ok,
  input  logic            ld_valid,
  input  logic [AW-1:0]   ld_addr,
  input  logic [DW-1:0]   cache_rdata,
  input  logic            flush,
  output logic [DW-1:0]   ld_data,
  output logic            cw_en,
  output logic [AW-1:0]   cw_addr,
  output logic [DW-1:0]   cw_data,
  output logic [DW/8-1:0] cw_be,
  output logic            miss_o,
  output logic            empty_o
);
  localparam int BW = DW / 8;

  logic          held, conf;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_data;
  logic [BW-1:0] h_be;

  wire usable = held & (conf | tc_ok);
  wire fwd    = usable & ld_valid & (ld_addr == h_addr);

  assign miss_o  = held & ~conf & ~tc_ok;
  assign cw_en   = usable & (~ld_valid | flush | st_valid);
  assign cw_addr = h_addr;
  assign cw_data = h_data;
  assign cw_be   = h_be;
  assign empty_o = ~held;

  for (genvar i = 0; i < BW; i++) begin : g_merge
    assign ld_data[i*8 +: 8] = (fwd & h_be[i]) ? h_data[i*8 +: 8] : cache_rdata[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= 1'b0;
      conf <= 1'b0;
    end else if (st_valid) begin
      held <= 1'b1;
      conf <= 1'b0;
    end else if (cw_en | miss_o) begin
      held <= 1'b0;
      conf <= 1'b0;
    end else if (held & tc_ok) begin
      conf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st_valid) begin
      h_addr <= st_addr;
      h_data <= st_data;
      h_be   <= st_be;
    end
  end

  p_no_write_on_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |-> !cw_en);
  p_miss_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_o && !st_valid) |=> empty_o);
  p_empty_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> !cw_en);
  p_write_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_en && !st_valid) |=> empty_o);
  p_store_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !empty_o);
  p_load_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_o && ld_valid && !flush && !st_valid && !miss_o) |=> !empty_o);
  p_flush_drains_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !st_valid) |=> empty_o);
endmodule

// File: tb/test_store_hold_buffer.sv
module test_store_hold_buffer;
  localparam int AW = 10, DW = 32, BW = DW / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, tc_ok = 0, ld_valid = 0, flush = 0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0, cache_rdata = '0;
  logic [BW-1:0] st_be = '0;
  logic [DW-1:0] ld_data, cw_data;
  logic [AW-1:0] cw_addr;
  logic [BW-1:0] cw_be;
  logic cw_en, miss_o, empty_o;
  int total = 0, bad = 0, cycles = 0;

  store_hold_buffer #(.AW(AW), .DW(DW)) i_store_hold_buffer (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_be(st_be), .tc_ok(tc_ok), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .cache_rdata(cache_rdata), .flush(flush), .ld_data(ld_data), .cw_en(cw_en),
    .cw_addr(cw_addr), .cw_data(cw_data), .cw_be(cw_be), .miss_o(miss_o), .empty_o(empty_o));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] c, input logic [DW-1:0] d,
                                          input logic [BW-1:0] be);
    logic [DW-1:0] r = c;
    for (int k = 0; k < BW; k++) if (be[k]) r[k*8 +: 8] = d[k*8 +: 8];
    return r;
  endfunction

  task automatic drive(input logic st, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                       input logic [BW-1:0] sb, input logic tc, input logic ld,
                       input logic [AW-1:0] la, input logic fl);
    @(negedge clk);
    st_valid = st; st_addr = sa; st_data = sd; st_be = sb;
    tc_ok = tc; ld_valid = ld; ld_addr = la; flush = fl;
    #2;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #2;
    chk("R1 empty", 64'(empty_o), 64'd1);
    chk("R1 cw_en", 64'(cw_en), 64'd0);
    chk("R1 miss", 64'(miss_o), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      logic [BW-1:0] be = BW'(i);
      logic [AW-1:0] a  = AW'(i * 7 + 3);
      logic [AW-1:0] b  = AW'(i * 7 + 200);
      logic [DW-1:0] d  = 32'h1122_3344 ^ {4{8'(i * 17)}};
      logic [DW-1:0] e  = ~d;
      cache_rdata = 32'hC3C3_3C3C ^ DW'(i);

      // load to an empty buffer passes through
      drive(0, 0, 0, 0, 0, 1, a, 0);
      chk("R8 empty load", 64'(ld_data), 64'(cache_rdata));

      // store, then confirm with a matching load
      drive(1, a, d, be, 0, 0, 0, 0);
      chk("R10 empty before capture", 64'(empty_o), 64'd1);
      drive(0, 0, 0, 0, 1, 1, a, 0);
      chk("R7 merge", 64'(ld_data), 64'(merge(cache_rdata, d, be)));
      chk("R4 stall", 64'(cw_en), 64'd0);
      chk("R10 held", 64'(empty_o), 64'd0);
      drive(0, 0, 0, 0, 0, 1, b, 0);
      chk("R8 other addr", 64'(ld_data), 64'(cache_rdata));
      chk("R4 still held", {63'd0, cw_en | empty_o}, 64'd0);
      drive(0, 0, 0, 0, 0, 0, 0, 0);
      chk("R3 write", {31'd0, cw_en, cw_addr, cw_be, cw_data}, {31'd0, 1'b1, a, be, d});
      drive(0, 0, 0, 0, 0, 1, a, 0);
      chk("R3 empty after", 64'(empty_o), 64'd1);
      chk("R8 drained load", 64'(ld_data), 64'(cache_rdata));

      // miss
      drive(1, b, e, be, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 1, b, 0);
      chk("R6 miss", 64'(miss_o), 64'd1);
      chk("R2 no write", 64'(cw_en), 64'd0);
      chk("R2 no forward", 64'(ld_data), 64'(cache_rdata));
      drive(0, 0, 0, 0, 0, 0, 0, 0);
      chk("R6 discarded", {62'd0, empty_o, cw_en}, 64'd2);

      // back-to-back stores
      drive(1, a, d, be, 0, 0, 0, 0);
      drive(1, b, e, ~be, 1, 0, 0, 0);
      chk("R5 old drained", {31'd0, cw_en, cw_addr, cw_be, cw_data}, {31'd0, 1'b1, a, be, d});
      drive(0, 0, 0, 0, 1, 0, 0, 0);
      chk("R5 new entry", {31'd0, cw_en, cw_addr, cw_be, cw_data}, {31'd0, 1'b1, b, ~be, e});
      drive(0, 0, 0, 0, 0, 0, 0, 0);
      chk("R10 empty end", 64'(empty_o), 64'd1);

      // flush under a load
      drive(1, b, d, be, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 1, 1, a, 0);
      drive(0, 0, 0, 0, 0, 1, a, 1);
      chk("R9 flush write", {31'd0, cw_en, cw_addr, cw_be, cw_data}, {31'd0, 1'b1, b, be, d});
      drive(0, 0, 0, 0, 0, 0, 0, 0);
      chk("R9 flushed", 64'(empty_o), 64'd1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule